// File: doc/BRIEF.md
# PCI Configuration Address Encoder

This block turns a configuration target (bus number, device slot, function number and register offset) into the two values that a host bridge needs to start a PCI configuration cycle through a 16 MB configuration window. The first value is a 24-bit offset into that window. The second is a 16-bit value for the window's map register, which supplies the upper address bits and the cycle type.

For bus 0 the block builds a type 0 cycle. It sets one device-select bit, which lands in the window offset for low slot numbers. For higher slot numbers the bit lands in the map value instead, because the 16 MB window cannot reach the upper address bits. For any other bus it builds a type 1 cycle, packing the bus, slot and function into the offset and letting the host drive the two lowest address bits.

A request is presented with a one-cycle valid strobe. The encoded result appears on registered outputs one clock later and stays there until the next request. Issuing the bus cycle itself is left to the surrounding logic.

Top module: `cfg_addr_encoder`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. Back-to-back strobes give back-to-back responses. Synchronous reset drives `rsp_valid`, `rsp_offset`, `rsp_map` and `rsp_err` to zero.
- R2: Every response carries the configuration cycle code 3'b101 in `rsp_map[3:1]`.
- R3: For bus 0, the function number appears in `rsp_offset[10:8]` and `rsp_map[0]` is 0, so the two lowest PCI address bits are driven as zero.
- R4: For bus 0 and slot 0 to 12, `rsp_offset` bit (slot + 11) is the only set bit in `rsp_offset[23:11]`, and `rsp_map[15:4]` is zero.
- R5: For bus 0 and slot 13 to 20, `rsp_map` bit (slot - 5) is the only set bit in `rsp_map[15:4]`, and `rsp_offset[23:11]` is zero.
- R6: For bus 0 and slot 21 to 31, `rsp_err` is 1. No select bit is set: `rsp_offset[23:11]` is zero and `rsp_map` equals 16'h000A. The function and register fields are still encoded.
- R7: For a non-zero bus, `rsp_offset` is {bus[7:0], slot[4:0], func[2:0], reg[7:0]}, `rsp_map` equals 16'h000B (bit 0 set, so the host supplies the lowest address bits), and `rsp_err` is 0.
- R8: In every response, `rsp_offset[7:0]` equals the register offset of the request.
- R9: In a cycle without a strobe, `rsp_offset`, `rsp_map` and `rsp_err` keep the values of the previous response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_bus | input | 8 | Target bus number |
| req_slot | input | 5 | Target device slot |
| req_func | input | 3 | Target function number |
| req_reg | input | 8 | Configuration register byte offset |
| rsp_valid | output | 1 | Response strobe, one cycle after `req_valid` |
| rsp_offset | output | 24 | Offset inside the 16 MB configuration window |
| rsp_map | output | 16 | Value for the window map register |
| rsp_err | output | 1 | Bus 0 slot too high to be selected |

## Verification
Every result of this block comes from a single register stage. Offset, map value, error flag and valid strobe are all due one clock after the strobe edge, and they then hold until the next strobe. The bench drives a request on a falling edge and reads the outputs on the next falling edge, half a cycle after the register has loaded. It reads them once more a cycle later to confirm that they held. One back-to-back pair of strobes confirms that each response follows its own request, with no gap in between.

// File: rtl/cfgenc_pkg.sv
package cfgenc_pkg;

    // Field widths of a configuration target
    localparam int BUS_W  = 8;
    localparam int SLOT_W = 5;
    localparam int FUNC_W = 3;
    localparam int REG_W  = 8;

    // Output widths: a 16 MB window offset and a 16-bit map value
    localparam int OFF_W  = 24;
    localparam int MAP_W  = 16;

    // The map value stands for address bits starting at this position
    localparam int MAP_SHIFT = 16;

    // Device select for slot s sits at address bit s + SEL_BASE
    localparam int SEL_BASE      = REG_W + FUNC_W;
    localparam int LOW_SLOT_MAX  = OFF_W - 1 - SEL_BASE;
    localparam int HIGH_SLOT_MAX = MAP_W - 1 + MAP_SHIFT - SEL_BASE;
    localparam int MAP_LO        = LOW_SLOT_MAX + 1 + SEL_BASE - MAP_SHIFT;
    localparam int OFF_SEL_N     = OFF_W - SEL_BASE;
    localparam int MAP_SEL_N     = MAP_W - MAP_LO;

    localparam logic [2:0] CYC_CONFIG = 3'b101;

    typedef enum logic {
        ADLOW_ZERO = 1'b0,
        ADLOW_HOST = 1'b1
    } adlow_e;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic [SLOT_W-1:0] slot;
        logic [FUNC_W-1:0] func;
        logic [REG_W-1:0]  regno;
    } cfg_req_t;

    typedef struct packed {
        logic             err;
        logic [MAP_W-1:0] map;
        logic [OFF_W-1:0] off;
    } cfg_enc_t;

    function automatic logic [MAP_W-1:0] map_base(adlow_e lo);
        return {{(MAP_W-4){1'b0}}, CYC_CONFIG, lo};
    endfunction

endpackage

// File: rtl/cfgenc_type0.sv
module cfgenc_type0
    import cfgenc_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [FUNC_W-1:0] func,
    input  logic [REG_W-1:0]  regno,
    output cfg_enc_t          enc
);

    logic [OFF_SEL_N-1:0] off_sel;
    logic [MAP_SEL_N-1:0] map_sel;

    // Low slots select inside the window offset
    for (genvar b = 0; b < OFF_SEL_N; b++) begin : g_off_sel
        assign off_sel[b] = (slot == SLOT_W'(b));
    end

    // Higher slots select through the map value
    for (genvar k = 0; k < MAP_SEL_N; k++) begin : g_map_sel
        assign map_sel[k] = (slot == SLOT_W'(LOW_SLOT_MAX + 1 + k));
    end

    always_comb begin
        enc.off = {off_sel, func, regno};
        enc.map = map_base(ADLOW_ZERO) | {map_sel, {MAP_LO{1'b0}}};
        enc.err = (slot > SLOT_W'(HIGH_SLOT_MAX));
    end

endmodule

// File: rtl/cfgenc_type1.sv
module cfgenc_type1
    import cfgenc_pkg::*;
(
    input  cfg_req_t req,
    output cfg_enc_t enc
);

    always_comb begin
        enc.off = {req.bus, req.slot, req.func, req.regno};
        enc.map = map_base(ADLOW_HOST);
        enc.err = 1'b0;
    end

endmodule

// File: rtl/cfgenc_outreg.sv
module cfgenc_outreg
    import cfgenc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  cfg_enc_t in_enc,
    output logic     out_valid,
    output cfg_enc_t out_enc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_enc   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_enc <= in_enc;
            end
        end
    end

endmodule

// File: rtl/cfg_addr_encoder.sv
module cfg_addr_encoder
    import cfgenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [REG_W-1:0]  req_reg,
    output logic              rsp_valid,
    output logic [OFF_W-1:0]  rsp_offset,
    output logic [MAP_W-1:0]  rsp_map,
    output logic              rsp_err
);

    cfg_req_t req;
    cfg_enc_t enc_t0, enc_t1, enc_sel, enc_q;
    logic     local_bus;

    assign req       = '{bus: req_bus, slot: req_slot, func: req_func, regno: req_reg};
    assign local_bus = (req_bus == '0);

    cfgenc_type0 i_type0 (
        .slot  (req.slot),
        .func  (req.func),
        .regno (req.regno),
        .enc   (enc_t0)
    );

    cfgenc_type1 i_type1 (
        .req (req),
        .enc (enc_t1)
    );

    assign enc_sel = local_bus ? enc_t0 : enc_t1;

    cfgenc_outreg i_outreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_enc    (enc_sel),
        .out_valid (rsp_valid),
        .out_enc   (enc_q)
    );

    assign rsp_offset = enc_q.off;
    assign rsp_map    = enc_q.map;
    assign rsp_err    = enc_q.err;

endmodule

module cfg_addr_encoder_chk
    import cfgenc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [BUS_W-1:0]  req_bus,
    input logic [REG_W-1:0]  req_reg,
    input logic              rsp_valid,
    input logic [OFF_W-1:0]  rsp_offset,
    input logic [MAP_W-1:0]  rsp_map,
    input logic              rsp_err
);

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_cyctype_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_map[3:1] == 3'b101);

    assert_onehot_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_map[0] && !rsp_err) |->
            $countones({rsp_offset[OFF_W-1:SEL_BASE], rsp_map[MAP_W-1:MAP_LO]}) == 1);

    assert_err_nosel_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> ({rsp_offset[OFF_W-1:SEL_BASE], rsp_map[MAP_W-1:4]} == '0) && !rsp_map[0]);

    assert_type1_map_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus != '0) |=>
            rsp_map[0] && !rsp_err && rsp_offset[OFF_W-1:OFF_W-BUS_W] == $past(req_bus));

    assert_regbyte_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_offset[REG_W-1:0] == $past(req_reg));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_offset) && $stable(rsp_map) && $stable(rsp_err));

endmodule

bind cfg_addr_encoder cfg_addr_encoder_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_bus    (req_bus),
    .req_reg    (req_reg),
    .rsp_valid  (rsp_valid),
    .rsp_offset (rsp_offset),
    .rsp_map    (rsp_map),
    .rsp_err    (rsp_err)
);

// File: tb/test_cfg_addr_encoder.sv
module test_cfg_addr_encoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_slot = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_reg = '0;
    logic        rsp_valid;
    logic [23:0] rsp_offset;
    logic [15:0] rsp_map;
    logic        rsp_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_addr_encoder i_cfg_addr_encoder (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_bus    (req_bus),
        .req_slot   (req_slot),
        .req_func   (req_func),
        .req_reg    (req_reg),
        .rsp_valid  (rsp_valid),
        .rsp_offset (rsp_offset),
        .rsp_map    (rsp_map),
        .rsp_err    (rsp_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected encoding computed from the requirements
    task automatic expect_of(input int bus, input int slot, input int func, input int rg,
                             output logic [23:0] off, output logic [15:0] map,
                             output logic err, output string tag);
        err = 1'b0;
        if (bus == 0) begin
            off = 24'((func << 8) | rg);
            map = 16'h000A;
            if (slot <= 12) begin
                off = off | 24'(1 << (slot + 11));
                tag = "R4";
            end else if (slot <= 20) begin
                map = map | 16'(1 << (slot - 5));
                tag = "R5";
            end else begin
                err = 1'b1;
                tag = "R6";
            end
        end else begin
            off = 24'((bus << 16) | (slot << 11) | (func << 8) | rg);
            map = 16'h000B;
            tag = "R7";
        end
    endtask

    task automatic check_rsp(int bus, int slot, int func, int rg);
        logic [23:0] eo;
        logic [15:0] em;
        logic        ee;
        string       tg;
        expect_of(bus, slot, func, rg, eo, em, ee, tg);
        chk("R1 valid", 32'(rsp_valid), 32'd1);
        chk({tg, " offset"}, 32'(rsp_offset), 32'(eo));
        chk({tg, " map"}, 32'(rsp_map), 32'(em));
        chk({tg, " err"}, 32'(rsp_err), 32'(ee));
        chk("R2 cycle type", 32'(rsp_map[3:1]), 32'd5);
        chk("R8 reg byte", 32'(rsp_offset[7:0]), 32'(rg));
        if (bus == 0) begin
            chk("R3 func field", 32'(rsp_offset[10:8]), 32'(func));
            chk("R3 map bit0", 32'(rsp_map[0]), 32'd0);
        end
    endtask

    task automatic one_req(int bus, int slot, int func, int rg);
        logic [23:0] eo;
        logic [15:0] em;
        logic        ee;
        string       tg;
        @(negedge clk);
        req_valid = 1'b1;
        req_bus = 8'(bus); req_slot = 5'(slot); req_func = 3'(func); req_reg = 8'(rg);
        @(negedge clk);
        req_valid = 1'b0;
        req_bus = ~req_bus; req_slot = ~req_slot; req_func = ~req_func; req_reg = ~req_reg;
        check_rsp(bus, slot, func, rg);
        @(negedge clk);
        expect_of(bus, slot, func, rg, eo, em, ee, tg);
        chk("R1 no strobe", 32'(rsp_valid), 32'd0);
        chk("R9 hold", {7'd0, rsp_err, rsp_offset}, {7'd0, ee, eo});
        chk("R9 hold map", 32'(rsp_map), 32'(em));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        int buses[4] = '{0, 1, 8'h5A, 8'hFF};
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(rsp_valid), 32'd0);
        chk("R1 reset offset", 32'(rsp_offset), 32'd0);
        chk("R1 reset map", 32'(rsp_map), 32'd0);
        chk("R1 reset err", 32'(rsp_err), 32'd0);
        rst = 1'b0;

        foreach (buses[i]) begin
            for (int s = 0; s < 32; s++) begin
                for (int f = 0; f < 8; f++) begin
                    one_req(buses[i], s, f, ((s * 8 + f) * 7 + i * 13) & 8'hFF);
                end
            end
        end

        // Back-to-back strobes (R1)
        @(negedge clk);
        req_valid = 1'b1;
        req_bus = 8'd0; req_slot = 5'd16; req_func = 3'd2; req_reg = 8'h3C;
        @(negedge clk);
        check_rsp(0, 16, 2, 8'h3C);
        req_bus = 8'd3; req_slot = 5'd9; req_func = 3'd6; req_reg = 8'h44;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(3, 9, 6, 8'h44);
        @(negedge clk);
        chk("R1 after pair", 32'(rsp_valid), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule